// File: doc/BRIEF.md
# Call-Waiting Alert Qualification Sequencer

This block decides whether a high level on a dual-tone detector output is a real call-waiting alert burst or was caused by speech. It watches the detector's level once per millisecond tick and measures how long it stays high. Local speech is muted while the measurement is still running. A burst whose length falls inside an accepted window makes the block switch the detector into its FSK energy mode. The block then requires a quiet interval before it declares the alert valid.

After a valid alert, mute stays on and the detector stays in FSK energy mode until the surrounding controller strobes that the transaction is done. A burst that is too short, a burst that is too long, or energy during the quiet check all return the block to idle, with mute released and tone-alert mode selected. The detector input is synchronised to the block clock. It is only examined on tick cycles, so every time limit is a count of ticks.

Two timing options are supported through parameters. In the first, mute is applied on the very first high sample (`T1_MS = 0`, `T3_MS = 15`). In the second, mute is applied only after the burst has lasted a while (`T1_MS = 15`, `T3_MS` from 25 to 30). The upper pulse bound (`TMAX_MS`, 65) and the quiet window (`QUIET_MS`, 50, at least 30) are also parameters.

Top module: `cwa_qualifier`

## Requirements
- R1: A synchronous reset (`rst_i` high at a clock edge) forces `mute_o`, `fsk_mode_o` and `alert_valid_o` to 0 and returns the block to idle, including when the reset arrives in the middle of a measurement.
- R2: Let n be the number of consecutive tick samples that see DET high, counted from the rising sample. If n < `T3_MS`, mute is released at the tick where DET is first seen low. The block is then idle, with `fsk_mode_o` 0 and no valid pulse.
- R3: `mute_o` goes to 1 at the `T1_MS`-th tick after the rising sample, provided DET is still high there. With `T1_MS` = 0 it goes to 1 at the rising-sample tick itself.
- R4: If `T3_MS` <= n <= `TMAX_MS`, then at the tick where DET is first seen low `fsk_mode_o` goes to 1 (1 = FSK energy mode, 0 = tone-alert mode) and `mute_o` stays at 1.
- R5: If n > `TMAX_MS`, mute is released at the `TMAX_MS`-th tick after the rising sample. FSK mode is never selected for that burst. No new measurement starts until DET has been seen low and then high again.
- R6: During the quiet check, DET seen high at any of the first `QUIET_MS` ticks releases mute, returns to tone-alert mode and produces no valid pulse. If DET stays high afterwards, that does not start a new measurement.
- R7: If DET stays low for `QUIET_MS` ticks after FSK mode is selected, `alert_valid_o` is high for exactly one clock cycle at the `QUIET_MS`-th tick. `mute_o` and `fsk_mode_o` both remain 1.
- R8: After a valid alert, `mute_o` and `fsk_mode_o` stay at 1 until a one-cycle `done_i` pulse arrives. On the cycle after that pulse both are 0. A `done_i` pulse in any other state has no effect.
- R9: DET excursions that do not reach a tick sample, after the two-cycle synchroniser, are ignored. Outputs change only on tick cycles, on `done_i`, or on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_i | input | 1 | Synchronous reset, active high |
| det_i | input | 1 | Dual-tone / energy detector level, asynchronous |
| tick_i | input | 1 | One-cycle pulse every millisecond |
| done_i | input | 1 | One-cycle strobe: alert transaction finished |
| mute_o | output | 1 | 1 = mute local speech |
| fsk_mode_o | output | 1 | Detector mode select: 1 = FSK energy, 0 = tone alert |
| alert_valid_o | output | 1 | One-cycle pulse when an alert is accepted |

## Verification
Bursts are driven with lengths on both sides of `T3_MS` and `TMAX_MS`, which separates the short, accepted and over-long outcomes. Gaps just below and at `QUIET_MS` separate a quiet-check rejection from an acceptance. Two instances, one muting immediately and one muting after 15 ticks, receive the same stimulus, which shows whether mute timing follows the parameter. Sub-tick glitches, `done_i` strobes in non-accepting states and a mid-burst reset show that input is sampled only on ticks, that stray strobes are ignored and that reset reaches idle.

// File: rtl/cwa_pkg.sv
package cwa_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_HOLD_T1  = 3'd1,
        ST_MEASURE  = 3'd2,
        ST_QUIET    = 3'd3,
        ST_ACCEPTED = 3'd4,
        ST_DRAIN    = 3'd5
    } cwa_state_e;

    typedef struct packed {
        cwa_state_e state;
        logic       mute;
        logic       fsk;
        logic       valid;
    } cwa_ctl_t;

    localparam cwa_ctl_t CWA_CTL_RST = '{state: ST_IDLE, mute: 1'b0, fsk: 1'b0, valid: 1'b0};

endpackage

// File: rtl/cwa_det_sampler.sv
// Synchronises the detector level and tracks its value at the previous tick.
module cwa_det_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic det_i,
    input  logic tick_i,
    output logic det_lvl_o,
    output logic det_rise_o
);

    logic [SYNC_STAGES-1:0] sync_q, sync_d;
    logic                   prev_q, prev_d;

    always_comb begin
        sync_d = {sync_q[SYNC_STAGES-2:0], det_i};
        prev_d = tick_i ? sync_q[SYNC_STAGES-1] : prev_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign det_lvl_o  = sync_q[SYNC_STAGES-1];
    assign det_rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;

endmodule

// File: rtl/cwa_ms_timer.sv
// Saturating millisecond counter; el_o is the value after the next step.
module cwa_ms_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             clr_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] el_o
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [CNT_W-1:0] cnt_q, cnt_d;

    assign el_o = (cnt_q == CNT_TOP) ? CNT_TOP : cnt_q + 1'b1;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (step_i) begin
            cnt_d = el_o;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/cwa_qualifier.sv
module cwa_qualifier
    import cwa_pkg::*;
#(
    parameter int T1_MS       = 15,
    parameter int T3_MS       = 27,
    parameter int TMAX_MS     = 65,
    parameter int QUIET_MS    = 50,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic det_i,
    input  logic tick_i,
    input  logic done_i,
    output logic mute_o,
    output logic fsk_mode_o,
    output logic alert_valid_o
);

    localparam int LIMIT = (TMAX_MS > QUIET_MS) ? TMAX_MS : QUIET_MS;
    localparam int CNT_W = $clog2(LIMIT + 1) + 1;

    localparam logic [CNT_W-1:0] T1_L    = CNT_W'(T1_MS);
    localparam logic [CNT_W-1:0] T3_L    = CNT_W'(T3_MS);
    localparam logic [CNT_W-1:0] TMAX_L  = CNT_W'(TMAX_MS);
    localparam logic [CNT_W-1:0] QUIET_L = CNT_W'(QUIET_MS);

    cwa_ctl_t         ctl_q, ctl_d;
    logic             det_lvl, det_rise;
    logic             tmr_clr, tmr_step;
    logic [CNT_W-1:0] el;
    cwa_state_e       arm_state;
    logic             arm_mute;

    cwa_det_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .det_i      (det_i),
        .tick_i     (tick_i),
        .det_lvl_o  (det_lvl),
        .det_rise_o (det_rise)
    );

    cwa_ms_timer #(.CNT_W(CNT_W)) u_timer (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .clr_i  (tmr_clr),
        .step_i (tmr_step),
        .el_o   (el)
    );

    // With no pre-mute delay the rising sample enters the measurement muted.
    generate
        if (T1_MS == 0) begin : g_mute_at_rise
            assign arm_state = ST_MEASURE;
            assign arm_mute  = 1'b1;
        end else begin : g_mute_after_t1
            assign arm_state = ST_HOLD_T1;
            assign arm_mute  = 1'b0;
        end
    endgenerate

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.valid = 1'b0;
        tmr_clr     = 1'b0;
        tmr_step    = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                tmr_clr    = 1'b1;
                ctl_d.mute = 1'b0;
                ctl_d.fsk  = 1'b0;
                if (tick_i && det_rise) begin
                    ctl_d.state = arm_state;
                    ctl_d.mute  = arm_mute;
                end
            end
            ST_HOLD_T1: begin
                if (tick_i) begin
                    if (!det_lvl) begin
                        ctl_d.state = ST_IDLE;
                        tmr_clr     = 1'b1;
                    end else begin
                        tmr_step = 1'b1;
                        if (el >= T1_L) begin
                            ctl_d.state = ST_MEASURE;
                            ctl_d.mute  = 1'b1;
                        end
                    end
                end
            end
            ST_MEASURE: begin
                if (tick_i) begin
                    if (!det_lvl) begin
                        tmr_clr = 1'b1;
                        if (el < T3_L) begin
                            ctl_d.state = ST_IDLE;
                            ctl_d.mute  = 1'b0;
                        end else begin
                            ctl_d.state = ST_QUIET;
                            ctl_d.fsk   = 1'b1;
                        end
                    end else begin
                        tmr_step = 1'b1;
                        if (el >= TMAX_L) begin
                            ctl_d.state = ST_DRAIN;
                            ctl_d.mute  = 1'b0;
                        end
                    end
                end
            end
            ST_QUIET: begin
                if (tick_i) begin
                    if (det_lvl) begin
                        ctl_d.state = ST_IDLE;
                        ctl_d.mute  = 1'b0;
                        ctl_d.fsk   = 1'b0;
                        tmr_clr     = 1'b1;
                    end else if (el >= QUIET_L) begin
                        ctl_d.state = ST_ACCEPTED;
                        ctl_d.valid = 1'b1;
                        tmr_clr     = 1'b1;
                    end else begin
                        tmr_step = 1'b1;
                    end
                end
            end
            ST_ACCEPTED: begin
                tmr_clr = 1'b1;
                if (done_i) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.mute  = 1'b0;
                    ctl_d.fsk   = 1'b0;
                end
            end
            ST_DRAIN: begin
                if (tick_i) begin
                    if (!det_lvl) begin
                        ctl_d.state = ST_IDLE;
                        tmr_clr     = 1'b1;
                    end else begin
                        tmr_step = 1'b1;
                    end
                end
            end
            default: begin
                ctl_d   = CWA_CTL_RST;
                tmr_clr = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctl_q <= CWA_CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mute_o        = ctl_q.mute;
    assign fsk_mode_o    = ctl_q.fsk;
    assign alert_valid_o = ctl_q.valid;

endmodule

// File: rtl/cwa_qualifier_chk.sv
module cwa_qualifier_chk
    import cwa_pkg::*;
(
    input logic       clk_i,
    input logic       rst_i,
    input logic       tick_i,
    input logic       done_i,
    input logic       mute_i,
    input logic       fsk_i,
    input logic       valid_i,
    input cwa_state_e state_i
);

    logic armed_q = 1'b0;

    always_ff @(posedge clk_i) begin
        armed_q <= !rst_i;
    end

    AST_VALID_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
        valid_i |=> !valid_i) else $error("valid pulse longer than one cycle"); // R7

    AST_VALID_WHILE_HELD: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
        valid_i |-> (mute_i && fsk_i)) else $error("valid without mute and fsk"); // R7

    AST_FSK_NEEDS_MUTE: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
        fsk_i |-> mute_i) else $error("fsk mode without mute"); // R4

    AST_FSK_ENTRY_ON_TICK: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
        $rose(fsk_i) |-> $past(tick_i)) else $error("fsk mode entered off tick"); // R4

    AST_QUIET_BETWEEN_TICKS: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
        (!$past(tick_i) && !$past(done_i)) |-> ($stable(mute_i) && $stable(fsk_i)))
        else $error("outputs moved without tick or done"); // R9

    AST_DONE_RELEASES: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
        (state_i == ST_ACCEPTED && done_i) |=> (!mute_i && !fsk_i))
        else $error("done did not release mute and fsk"); // R8

endmodule

bind cwa_qualifier cwa_qualifier_chk u_cwa_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .tick_i  (tick_i),
    .done_i  (done_i),
    .mute_i  (mute_o),
    .fsk_i   (fsk_mode_o),
    .valid_i (alert_valid_o),
    .state_i (ctl_q.state)
);

// File: tb/test_cwa_qualifier.sv
module test_cwa_qualifier;

    localparam int TP     = 16;
    localparam int A_T1   = 15;
    localparam int A_T3   = 27;
    localparam int B_T1   = 0;
    localparam int B_T3   = 15;
    localparam int TMAX   = 65;
    localparam int QUIET  = 50;
    localparam int WD_LIM = 190000;

    logic clk  = 1'b0;
    logic rst  = 1'b1;
    logic det  = 1'b0;
    logic tick = 1'b0;
    logic done = 1'b0;
    logic mute_a, fsk_a, val_a;
    logic mute_b, fsk_b, val_b;

    int n_tests  = 0;
    int n_fail   = 0;
    int tick_cnt = 0;
    int cyc      = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        tick_cnt <= (tick_cnt == TP - 1) ? 0 : tick_cnt + 1;
        tick     <= (tick_cnt == TP - 1);
        cyc      <= cyc + 1;
    end

    cwa_qualifier i_cwa_qualifier (
        .clk_i(clk), .rst_i(rst), .det_i(det), .tick_i(tick), .done_i(done),
        .mute_o(mute_a), .fsk_mode_o(fsk_a), .alert_valid_o(val_a)
    );

    cwa_qualifier #(.T1_MS(B_T1), .T3_MS(B_T3)) i_cwa_fast (
        .clk_i(clk), .rst_i(rst), .det_i(det), .tick_i(tick), .done_i(done),
        .mute_o(mute_b), .fsk_mode_o(fsk_b), .alert_valid_o(val_b)
    );

    // ---- expected values from the requirements ----
    function automatic bit accepted(int t3, int n);
        return (n >= t3) && (n <= TMAX);
    endfunction

    // DET comes back during the quiet check only when both instances accepted.
    function automatic bit reraise(int n, int l);
        return (l < QUIET) && (n >= A_T3) && (n <= TMAX);
    endfunction

    function automatic bit exp_mute(int t1, int t3, int n, int l, int s);
        if (n > TMAX)     return (s >= t1 + 1) && (s <= TMAX);
        if (n < t3)       return (s >= t1 + 1) && (s <= n);
        if (reraise(n, l)) return (s >= t1 + 1) && (s <= n + 1 + l);
        return s >= t1 + 1;
    endfunction

    function automatic bit exp_fsk(int t3, int n, int l, int s);
        if (!accepted(t3, n)) return 1'b0;
        if (reraise(n, l))    return (s >= n + 1) && (s <= n + 1 + l);
        return s >= n + 1;
    endfunction

    function automatic bit exp_val(int t3, int n, int l, int s);
        return accepted(t3, n) && !reraise(n, l) && (s == n + 1 + QUIET);
    endfunction

    function automatic string mute_tag(int t3, int n, int s);
        if (s <= n) return (n > TMAX) ? "R5" : "R3";
        return (n < t3) ? "R2" : "R6";
    endfunction

    task automatic chk(string req, string what, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic step_tick();
        do @(negedge clk); while (tick !== 1'b1);
        @(negedge clk);
    endtask

    task automatic pulse_done();
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
    endtask

    task automatic check_idle(string req);
        chk(req, "mute_a", mute_a, 1'b0);
        chk(req, "fsk_a", fsk_a, 1'b0);
        chk(req, "valid_a", val_a, 1'b0);
        chk(req, "mute_b", mute_b, 1'b0);
        chk(req, "fsk_b", fsk_b, 1'b0);
        chk(req, "valid_b", val_b, 1'b0);
    endtask

    task automatic run_burst(int n, int l);
        int s_end;
        s_end = n + QUIET + 3;
        det = 1'b1;
        for (int s = 1; s <= s_end; s++) begin
            step_tick();
            chk(mute_tag(A_T3, n, s), "mute_a", mute_a, exp_mute(A_T1, A_T3, n, l, s));
            chk(mute_tag(B_T3, n, s), "mute_b", mute_b, exp_mute(B_T1, B_T3, n, l, s));
            chk("R4", "fsk_a", fsk_a, exp_fsk(A_T3, n, l, s));
            chk("R4", "fsk_b", fsk_b, exp_fsk(B_T3, n, l, s));
            chk("R7", "valid_a", val_a, exp_val(A_T3, n, l, s));
            chk("R7", "valid_b", val_b, exp_val(B_T3, n, l, s));
            if (s == n) det = 1'b0;
            if (reraise(n, l) && (s == n + 1 + l)) det = 1'b1;
            if (exp_val(A_T3, n, l, s) || exp_val(B_T3, n, l, s)) begin
                @(negedge clk);
                chk("R7", "valid_a next cycle", val_a, 1'b0);
                chk("R7", "valid_b next cycle", val_b, 1'b0);
            end
            // stray strobe outside the accepted state: must be ignored (R8)
            if (s == n + 2) pulse_done();
        end
        det = 1'b0;
        pulse_done();
        chk("R8", "mute_a after done", mute_a, 1'b0);
        chk("R8", "fsk_a after done", fsk_a, 1'b0);
        chk("R8", "mute_b after done", mute_b, 1'b0);
        chk("R8", "fsk_b after done", fsk_b, 1'b0);
        for (int k = 0; k < 3; k++) begin
            step_tick();
            check_idle("R8");
        end
    endtask

    // ---- watchdog ----
    always @(posedge clk) begin
        if (cyc == WD_LIM) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // ---- stimulus ----
    initial begin
        int n;
        int l;
        void'($urandom(32'h5EED_0C2A));
        repeat (5) @(negedge clk);
        check_idle("R1");
        rst = 1'b0;
        step_tick();
        check_idle("R1");

        // R9: glitch entirely between two tick samples
        step_tick();
        repeat (3) @(negedge clk);
        det = 1'b1;
        repeat (3) @(negedge clk);
        det = 1'b0;
        for (int k = 0; k < 5; k++) begin
            step_tick();
            chk("R9", "mute_a after glitch", mute_a, 1'b0);
            chk("R9", "mute_b after glitch", mute_b, 1'b0);
        end

        // R1: reset in the middle of a muted measurement
        det = 1'b1;
        for (int k = 0; k < 20; k++) step_tick();
        chk("R3", "mute_a at tick 20", mute_a, 1'b1);
        chk("R3", "mute_b at tick 20", mute_b, 1'b1);
        rst = 1'b1;
        det = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_idle("R1");
        rst = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step_tick();
            check_idle("R1");
        end

        // directed corners
        run_burst(1, 60);
        run_burst(14, 60);
        run_burst(15, 60);
        run_burst(16, 60);
        run_burst(26, 60);
        run_burst(27, 60);
        run_burst(40, 0);
        run_burst(40, 49);
        run_burst(40, 50);
        run_burst(30, 20);
        run_burst(65, 60);
        run_burst(66, 60);
        run_burst(80, 60);

        // constrained random bursts
        for (int k = 0; k < 12; k++) begin
            n = $urandom_range(80, 1);
            l = $urandom_range(60, 0);
            run_burst(n, l);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule